// File: doc/BRIEF.md
# Load-Reserve / Store-Conditional Reservation Monitor

This block holds a single reservation for an atomic read-modify-write built from a load-and-reserve followed by a store-conditional. A load-and-reserve that raises no fault records the aligned granule that holds its address. The granule is 2^GRANULE_LG bytes, 32 bytes by default. A later store-conditional in the same granule succeeds only if the reservation is still held. Any store-conditional drops the reservation, whether it succeeds or fails. A store from another agent that hits the reserved granule, seen on one of the snoop ports, also drops it.

Both operations are screened for faults in the cycle they are presented. An address that is not word-aligned gives an alignment fault. A page whose attributes mark it write-through, or a data cache held locked, gives a storage fault. A faulting operation leaves the reservation as it was, and a faulting store-conditional reports failure. Every result is registered and appears one cycle after the operation.

Top module: `resv_monitor`

## Requirements
- R1: A fault-free load-reserve (op_kind 2'b01) records the granule op_addr[ADDR_W-1:GRANULE_LG]. Any address in that granule then pairs with it, and an address in another granule does not.
- R2: A store-conditional (op_kind 2'b10) raises sc_done in the next cycle. sc_success is 1 in that cycle exactly when the op is fault-free and a reservation is held on its granule.
- R3: A fault-free store-conditional clears the reservation, whether it succeeds or fails. A second store-conditional with no load-reserve between them therefore fails.
- R4: A load-reserve or store-conditional with op_addr[WORD_LG-1:0] non-zero raises fault_align one cycle later. The storage fault is then held low, because alignment takes precedence.
- R5: An aligned load-reserve or store-conditional raises fault_storage one cycle later when page_attr[WT_BIT] (bit 3, the write-through attribute) is 1 or dcache_locked is 1.
- R6: A faulting operation leaves the reservation unchanged, and a faulting store-conditional reports sc_success 0.
- R7: A snooped store (snoop_valid[i] with address slice i) to the reserved granule clears the reservation. In the same cycle as a store-conditional it makes that store-conditional fail. A snoop to another granule has no effect.
- R8: A new fault-free load-reserve replaces any reservation already held, including one being snooped in the same cycle.
- R9: op_kind 2'b00 and 2'b11 are no operation. One cycle later sc_done, sc_success, fault_align and fault_storage are all 0, and the reservation is kept.
- R10: After reset no reservation is held and all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_kind | input | 2 | 01 load-reserve, 10 store-conditional, 00/11 none |
| op_addr | input | ADDR_W | Effective address of the operation |
| page_attr | input | ATTR_W | Page attribute bits; bit WT_BIT is write-through |
| dcache_locked | input | 1 | Data cache locked |
| snoop_valid | input | SNOOP_N | Per-port foreign store strobe |
| snoop_addr | input | SNOOP_N*ADDR_W | Foreign store addresses, port i in slice i |
| sc_done | output | 1 | A store-conditional was presented last cycle |
| sc_success | output | 1 | That store-conditional succeeded |
| fault_align | output | 1 | Last cycle's operation was misaligned |
| fault_storage | output | 1 | Last cycle's operation hit a storage fault |

## Verification
The bench builds the block with ADDR_W of 16 and two snoop ports. It keeps the default 32-byte granule, 4-byte word and write-through at attribute bit 3. Random addresses are held to four neighbouring granules, so load-reserves, store-conditionals and snoops from both ports collide often. Store-conditionals land in the same granule at other word offsets as well as in adjacent granules. Fault, snoop and replacement events fall in the same cycle as a store-conditional, which brings the precedence rules between them within reach.

// File: rtl/resv_pkg.sv
package resv_pkg;
   typedef enum logic [1:0] {
      OP_NONE = 2'b00,
      OP_LRSV = 2'b01,
      OP_SCND = 2'b10,
      OP_RSVD = 2'b11
   } resv_op_e;

   typedef struct packed {
      logic align;
      logic storage;
   } resv_fault_t;
endpackage

// File: rtl/resv_fault_decode.sv
module resv_fault_decode
   import resv_pkg::*;
#(
   parameter int WORD_LG = 2,
   parameter int ATTR_W  = 4,
   parameter int WT_BIT  = 3
) (
   input  logic              op_active,
   input  logic [WORD_LG-1:0] addr_low,
   input  logic [ATTR_W-1:0] attr,
   input  logic              locked,
   output resv_fault_t       flt
);
   logic misaligned;
   logic unused_attr;

   assign misaligned  = |addr_low;
   assign unused_attr = ^attr;

   // alignment wins over storage
   always_comb begin
      flt.align   = op_active & misaligned;
      flt.storage = op_active & ~misaligned & (attr[WT_BIT] | locked);
   end
endmodule

// File: rtl/resv_granule_cmp.sv
module resv_granule_cmp #(
   parameter int ADDR_W     = 32,
   parameter int GRANULE_LG = 5,
   localparam int TAG_W     = ADDR_W - GRANULE_LG
) (
   input  logic              probe_valid,
   input  logic [ADDR_W-1:0] probe_addr,
   input  logic              tag_valid,
   input  logic [TAG_W-1:0]  tag,
   output logic              hit
);
   logic unused_low;
   assign unused_low = ^probe_addr[GRANULE_LG-1:0];
   assign hit = probe_valid & tag_valid & (probe_addr[ADDR_W-1:GRANULE_LG] == tag);
endmodule

// File: rtl/resv_state.sv
module resv_state #(
   parameter int TAG_W = 27
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             set,
   input  logic [TAG_W-1:0] set_tag,
   input  logic             clear,
   output logic             held,
   output logic [TAG_W-1:0] tag
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held <= 1'b0;
         tag  <= '0;
      end else if (set) begin
         held <= 1'b1;
         tag  <= set_tag;
      end else if (clear) begin
         held <= 1'b0;
      end
   end
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
   import resv_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int GRANULE_LG = 5,
   parameter int WORD_LG    = 2,
   parameter int ATTR_W     = 4,
   parameter int WT_BIT     = 3,
   parameter int SNOOP_N    = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [1:0]                op_kind,
   input  logic [ADDR_W-1:0]         op_addr,
   input  logic [ATTR_W-1:0]         page_attr,
   input  logic                      dcache_locked,
   input  logic [SNOOP_N-1:0]        snoop_valid,
   input  logic [SNOOP_N*ADDR_W-1:0] snoop_addr,
   output logic                      sc_done,
   output logic                      sc_success,
   output logic                      fault_align,
   output logic                      fault_storage
);
   localparam int TAG_W = ADDR_W - GRANULE_LG;

   if (WORD_LG < 1 || GRANULE_LG < WORD_LG || GRANULE_LG >= ADDR_W) begin : g_bad_geom
      $error("resv_monitor: need 1 <= WORD_LG <= GRANULE_LG < ADDR_W");
   end
   if (WT_BIT < 0 || WT_BIT >= ATTR_W) begin : g_bad_attr
      $error("resv_monitor: WT_BIT outside page_attr");
   end
   if (SNOOP_N < 1) begin : g_bad_snoop
      $error("resv_monitor: SNOOP_N must be at least 1");
   end

   resv_op_e    opk;
   logic        is_lr, is_sc, op_active;
   resv_fault_t flt;
   logic        fault_any;
   logic        held;
   logic [TAG_W-1:0] held_tag;
   logic        op_hit;
   logic [SNOOP_N-1:0] snoop_hits;
   logic        snoop_hit;
   logic        lr_take, sc_take, sc_pass;

   assign opk       = resv_op_e'(op_kind);
   assign is_lr     = (opk == OP_LRSV);
   assign is_sc     = (opk == OP_SCND);
   assign op_active = is_lr | is_sc;

   resv_fault_decode #(
      .WORD_LG (WORD_LG),
      .ATTR_W  (ATTR_W),
      .WT_BIT  (WT_BIT)
   ) u_fault (
      .op_active (op_active),
      .addr_low  (op_addr[WORD_LG-1:0]),
      .attr      (page_attr),
      .locked    (dcache_locked),
      .flt       (flt)
   );

   assign fault_any = flt.align | flt.storage;

   resv_granule_cmp #(
      .ADDR_W     (ADDR_W),
      .GRANULE_LG (GRANULE_LG)
   ) u_op_cmp (
      .probe_valid (is_sc),
      .probe_addr  (op_addr),
      .tag_valid   (held),
      .tag         (held_tag),
      .hit         (op_hit)
   );

   for (genvar gi = 0; gi < SNOOP_N; gi++) begin : g_snoop
      resv_granule_cmp #(
         .ADDR_W     (ADDR_W),
         .GRANULE_LG (GRANULE_LG)
      ) u_snoop_cmp (
         .probe_valid (snoop_valid[gi]),
         .probe_addr  (snoop_addr[gi*ADDR_W +: ADDR_W]),
         .tag_valid   (held),
         .tag         (held_tag),
         .hit         (snoop_hits[gi])
      );
   end

   assign snoop_hit = |snoop_hits;
   assign lr_take   = is_lr & ~fault_any;
   assign sc_take   = is_sc & ~fault_any;
   assign sc_pass   = sc_take & op_hit & ~snoop_hit;

   resv_state #(
      .TAG_W (TAG_W)
   ) u_state (
      .clk     (clk),
      .rst_n   (rst_n),
      .set     (lr_take),
      .set_tag (op_addr[ADDR_W-1:GRANULE_LG]),
      .clear   (sc_take | snoop_hit),
      .held    (held),
      .tag     (held_tag)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sc_done       <= 1'b0;
         sc_success    <= 1'b0;
         fault_align   <= 1'b0;
         fault_storage <= 1'b0;
      end else begin
         sc_done       <= is_sc;
         sc_success    <= sc_pass;
         fault_align   <= flt.align;
         fault_storage <= flt.storage;
      end
   end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
   parameter int WORD_LG = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic [1:0]         op_kind,
   input logic [WORD_LG-1:0] op_low,
   input logic               wt_attr,
   input logic               dcache_locked,
   input logic               sc_done,
   input logic               sc_success,
   input logic               fault_align,
   input logic               fault_storage
);
   logic is_op;
   assign is_op = (op_kind == 2'b01) || (op_kind == 2'b10);

   // R2: every store-conditional is answered one cycle later
   a_r2_done_after_sc: assert property (@(posedge clk) disable iff (!rst_n)
      (op_kind == 2'b10) |=> sc_done);

   // R2: success only ever comes with done
   a_r2_success_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
      sc_success |-> sc_done);

   // R3: back-to-back store-conditionals cannot both succeed
   a_r3_single_use: assert property (@(posedge clk) disable iff (!rst_n)
      (sc_success && op_kind == 2'b10) |=> !sc_success);

   // R4: misaligned op gives alignment fault only
   a_r4_align_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (is_op && (|op_low)) |=> (fault_align && !fault_storage));

   // R5: aligned op on write-through page or locked cache
   a_r5_storage_fault: assert property (@(posedge clk) disable iff (!rst_n)
      (is_op && !(|op_low) && (wt_attr || dcache_locked)) |=> fault_storage);

   // R6: a fault never accompanies a success
   a_r6_fault_blocks_success: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_align || fault_storage) |-> !sc_success);

   // R9: no operation gives quiet outputs
   a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !is_op |=> (!sc_done && !fault_align && !fault_storage));
endmodule

bind resv_monitor resv_monitor_chk #(
   .WORD_LG (WORD_LG)
) u_resv_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .op_kind       (op_kind),
   .op_low        (op_addr[WORD_LG-1:0]),
   .wt_attr       (page_attr[WT_BIT]),
   .dcache_locked (dcache_locked),
   .sc_done       (sc_done),
   .sc_success    (sc_success),
   .fault_align   (fault_align),
   .fault_storage (fault_storage)
);

// File: tb/test_resv_monitor.sv
module test_resv_monitor;
   localparam int AW = 16;
   localparam int GL = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    op_kind = 2'b00;
   logic [AW-1:0] op_addr = '0;
   logic [3:0]    page_attr = '0;
   logic          dcache_locked = 1'b0;
   logic [1:0]    snoop_valid = '0;
   logic [2*AW-1:0] snoop_addr = '0;
   logic          sc_done, sc_success, fault_align, fault_storage;

   int n_checks = 0;
   int n_fail   = 0;

   // bench model of the reservation
   logic          m_held = 1'b0;
   logic [AW-GL-1:0] m_tag = '0;

   always #5 clk = ~clk;

   resv_monitor #(
      .ADDR_W (AW), .GRANULE_LG (GL), .WORD_LG (2),
      .ATTR_W (4), .WT_BIT (3), .SNOOP_N (2)
   ) i_resv_monitor (
      .clk (clk), .rst_n (rst_n), .op_kind (op_kind), .op_addr (op_addr),
      .page_attr (page_attr), .dcache_locked (dcache_locked),
      .snoop_valid (snoop_valid), .snoop_addr (snoop_addr),
      .sc_done (sc_done), .sc_success (sc_success),
      .fault_align (fault_align), .fault_storage (fault_storage)
   );

   function automatic logic [AW-GL-1:0] gran(input logic [AW-1:0] a);
      return a[AW-1:GL];
   endfunction

   task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: {done,ok,align,storage} actual %b expected %b", req, got, exp);
      end
   endtask

   // one cycle: drive at negedge, check registered outputs at the next negedge
   task automatic step(input logic [1:0] k, input logic [AW-1:0] a, input logic [3:0] at,
                       input logic lk, input logic [1:0] sv,
                       input logic [AW-1:0] s0, input logic [AW-1:0] s1, input string req);
      logic is_op, mis, sto, fa, fs, ok, shit;
      string r;
      op_kind = k; op_addr = a; page_attr = at; dcache_locked = lk;
      snoop_valid = sv; snoop_addr = {s1, s0};
      is_op = (k == 2'b01) || (k == 2'b10);
      mis   = a[1:0] != 2'b00;
      sto   = at[3] | lk;
      fa    = is_op & mis;
      fs    = is_op & ~mis & sto;
      shit  = m_held & ((sv[0] && gran(s0) == m_tag) || (sv[1] && gran(s1) == m_tag));
      ok    = (k == 2'b10) & ~fa & ~fs & m_held & (gran(a) == m_tag) & ~shit;
      if (shit) m_held = 1'b0;
      if (is_op && !fa && !fs) begin
         if (k == 2'b01) begin m_held = 1'b1; m_tag = gran(a); end
         else m_held = 1'b0;
      end
      r = req;
      if (r == "") r = fa ? "R4" : fs ? "R5" : (k == 2'b10) ? "R2" : (k == 2'b01) ? "R1" : "R9";
      @(negedge clk);
      op_kind = 2'b00; snoop_valid = '0;
      check(r, {sc_done, sc_success, fault_align, fault_storage},
               {(k == 2'b10), ok, fa, fs});
   endtask

   task automatic op(input logic [1:0] k, input logic [AW-1:0] a, input string req);
      step(k, a, 4'h0, 1'b0, 2'b00, '0, '0, req);
   endtask

   localparam logic [AW-1:0] A = 16'h1240;
   localparam logic [AW-1:0] B = 16'h2300;

   initial begin : watchdog
      #2000000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin : main
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check("R10", {sc_done, sc_success, fault_align, fault_storage}, 4'b0000);
      op(2'b10, A, "R10");                        // no reservation after reset
      // R1 and R2: pair within one granule
      op(2'b01, A, "R1"); op(2'b10, A, "R2");
      op(2'b10, A, "R3");                         // second use fails
      op(2'b01, A, "R1"); op(2'b10, A + 16'd12, "R1");
      op(2'b01, A, "R1"); op(2'b10, A + 16'd32, "R1");
      op(2'b10, A, "R3");                         // failed SC also cleared it
      // R4 and R6: misaligned SC keeps the reservation
      op(2'b01, A, "R1"); op(2'b10, A + 16'd1, "R4"); op(2'b10, A, "R6");
      // R4 precedence over storage, reservation kept
      op(2'b01, A, "R1");
      step(2'b01, B + 16'd2, 4'h8, 1'b1, 2'b00, '0, '0, "R4");
      op(2'b10, A, "R6");
      // R5 write-through and locked cache
      op(2'b01, A, "R1");
      step(2'b10, A, 4'h8, 1'b0, 2'b00, '0, '0, "R5");
      op(2'b10, A, "R6");
      op(2'b01, A, "R1");
      step(2'b01, B, 4'h7, 1'b1, 2'b00, '0, '0, "R5");
      op(2'b10, A, "R6");
      // R7 snoops
      op(2'b01, A, "R1");
      step(2'b00, '0, 4'h0, 1'b0, 2'b10, '0, A + 16'd8, "R7");
      op(2'b10, A, "R7");
      op(2'b01, A, "R1");
      step(2'b00, '0, 4'h0, 1'b0, 2'b11, B, A + 16'd32, "R7");
      op(2'b10, A, "R7");
      op(2'b01, A, "R1");
      step(2'b10, A, 4'h0, 1'b0, 2'b01, A + 16'd4, '0, "R7");
      // R8 replacement, including against a same-cycle snoop
      op(2'b01, A, "R1"); op(2'b01, B, "R8"); op(2'b10, A, "R8");
      op(2'b01, A, "R1"); op(2'b01, B, "R8"); op(2'b10, B, "R8");
      op(2'b01, A, "R1");
      step(2'b01, A, 4'h0, 1'b0, 2'b01, A, '0, "R8");
      op(2'b10, A, "R8");
      // R9 reserved encoding ignored
      op(2'b01, A, "R1");
      step(2'b11, B + 16'd1, 4'h8, 1'b1, 2'b00, '0, '0, "R9");
      op(2'b10, A, "R9");
      // random mix in four granules
      for (int i = 0; i < 3000; i++) begin
         logic [1:0] k;
         logic [AW-1:0] a, s0, s1;
         logic [3:0] at;
         logic lk;
         logic [1:0] sv;
         int pick;
         pick = $urandom_range(0, 9);
         k  = (pick < 4) ? 2'b01 : (pick < 8) ? 2'b10 : 2'($urandom_range(0, 3));
         a  = A + AW'($urandom_range(0, 3) * 32) + AW'($urandom_range(0, 7) * 4);
         if ($urandom_range(0, 7) == 0) a = a + AW'($urandom_range(1, 3));
         at = ($urandom_range(0, 9) == 0) ? 4'h8 : 4'($urandom_range(0, 7));
         lk = ($urandom_range(0, 9) == 0);
         sv = {($urandom_range(0, 5) == 0), ($urandom_range(0, 5) == 0)};
         s0 = A + AW'($urandom_range(0, 3) * 32) + AW'($urandom_range(0, 31));
         s1 = A + AW'($urandom_range(0, 3) * 32) + AW'($urandom_range(0, 31));
         step(k, a, at, lk, sv, s0, s1, "");
      end
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule